// File: doc/BRIEF.md
# Fixed-Point Direct Form II Biquad Section

This block is one second-order recursive filter section for fixed-point streams. When a sample arrives with its valid strobe, the block multiplies it by a section gain. It subtracts two weighted copies of the stored recursive state from that product. The difference is rounded and clamped back to sample width to give the new state value. A second stage then weights the new state and the two older states with the numerator coefficients, rounds and clamps the sum, and presents the result with its own valid strobe.

Coefficients are static inputs, held steady while samples flow. Several instances can be chained to build higher-order filters, one section per instance. Every product is kept at full width until the single reduction at each of the two rounding points. Overflow at either point clamps to the extreme code of the sample format; it never wraps.

Top module: `iir_sos_df2`

## Requirements
- R1: A synchronous active-high reset clears both stored states, the intermediate stage and the output. After reset `out_valid` is 0 and `out_data` is 0. The first sample after reset sees zero history.
- R2: A sample taken with `in_valid` high on a clock edge produces `out_valid` high right after the next edge after that one. `out_valid` is high for exactly one cycle per accepted sample, and samples may arrive on consecutive cycles.
- R3: The new state is the rounded and clamped value of `coef_gain*in_data - (coef_a1*d1 + coef_a2*d2)`. Here d1 is the newest stored state and d2 the older one. The two feedback products are summed at full width before the subtraction. On an accepted sample d1 moves into d2.
- R4: The output is the rounded and clamped value of `coef_b0*d0 + coef_b1*d1 + coef_b2*d2`. Here d0 is the state just computed, and d1 and d2 are the states stored before this sample.
- R5: All coefficients are two's-complement with 16 fraction bits, covering -2.0 up to just below +2.0, so 65536 means 1.0. Each reduction adds 2^15 and then shifts arithmetically right by 16. Exact halves therefore round toward plus infinity: 62.5 becomes 63, and -60.5 becomes -60.
- R6: If the reduced state falls outside the 18-bit range, it is stored as +131071 or -131072.
- R7: If the reduced output falls outside the 18-bit range, it becomes +131071 or -131072, independently of whether the state clamped.
- R8: On cycles with `in_valid` low, neither stored state nor `out_data` changes, and `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 18 | Signed input sample |
| coef_gain | input | 18 | Section gain applied to the input |
| coef_a1 | input | 18 | Feedback weight of the newest state |
| coef_a2 | input | 18 | Feedback weight of the older state |
| coef_b0 | input | 18 | Feedforward weight of the new state |
| coef_b1 | input | 18 | Feedforward weight of the newest stored state |
| coef_b2 | input | 18 | Feedforward weight of the older stored state |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 18 | Signed filtered sample |

## Verification
A decaying impulse with a half-gain pole walks through exact-half values of both signs. A design that truncates, or rounds half away from zero, drifts off the tabulated sequence within a few samples. Full-scale inputs with large gain and feedback drive the state and the output past the 18-bit range, each alone and together. A wrapping design flips sign there, and a design with only one clamp point misses the other. Idle gaps between samples, a back-to-back burst and a reset in the middle of a run expose a state that advances without a valid sample, a strobe off by a cycle, and history that survives reset.

// File: rtl/sos_pkg.sv
package sos_pkg;

   // Fraction bits of the coefficient format used when no override is given.
   localparam int SOS_FRAC_W_DEF = 16;

   // Width that holds a sum of n_terms products of prod_w bits without overflow.
   function automatic int acc_width(input int prod_w, input int n_terms);
      return prod_w + $clog2(n_terms);
   endfunction

endpackage

// File: rtl/sos_prod_sum.sv
module sos_prod_sum #(
   parameter int DATA_W  = 18,
   parameter int COEF_W  = 18,
   parameter int N_TERMS = 2,
   parameter int ACC_W   = 37
) (
   input  logic signed [DATA_W-1:0] samp_i [N_TERMS],
   input  logic signed [COEF_W-1:0] coef_i [N_TERMS],
   output logic signed [ACC_W-1:0]  sum_o
);
   localparam int PROD_W = DATA_W + COEF_W;

   if (N_TERMS < 1) begin : g_bad_terms
      $error("sos_prod_sum: N_TERMS must be at least 1");
   end
   if (ACC_W < PROD_W + $clog2(N_TERMS)) begin : g_bad_acc
      $error("sos_prod_sum: ACC_W too narrow for a full-precision sum");
   end

   logic signed [ACC_W-1:0] chain [N_TERMS+1];
   assign chain[0] = '0;

   for (genvar i = 0; i < N_TERMS; i++) begin : g_term
      logic signed [PROD_W-1:0] prod;
      assign prod         = PROD_W'(samp_i[i]) * PROD_W'(coef_i[i]);
      assign chain[i+1]   = chain[i] + ACC_W'(prod);
   end

   assign sum_o = chain[N_TERMS];
endmodule

// File: rtl/sos_round_sat.sv
module sos_round_sat #(
   parameter int IN_W   = 38,
   parameter int FRAC_W = 16,
   parameter int OUT_W  = 18
) (
   input  logic signed [IN_W-1:0]  acc_i,
   output logic signed [OUT_W-1:0] res_o
);
   localparam int SH_W   = IN_W + 1;
   localparam int KEEP_W = SH_W - FRAC_W;

   if (FRAC_W < 1 || FRAC_W >= IN_W) begin : g_bad_frac
      $error("sos_round_sat: FRAC_W must lie in 1..IN_W-1");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("sos_round_sat: OUT_W must be at least 2");
   end

   logic signed [SH_W-1:0] acc_ext;
   logic signed [SH_W-1:0] half_lsb;
   logic signed [SH_W-1:0] biased;
   logic signed [SH_W-1:0] shifted;

   assign acc_ext  = SH_W'(acc_i);
   assign half_lsb = SH_W'(1) <<< (FRAC_W - 1);
   assign biased   = acc_ext + half_lsb;
   assign shifted  = biased >>> FRAC_W;

   if (KEEP_W <= OUT_W) begin : g_no_clip
      // The reduced value always fits: no clamp logic needed.
      assign res_o = OUT_W'(shifted);
   end else begin : g_clip
      localparam logic signed [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
      localparam logic signed [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};
      logic [SH_W-OUT_W:0] top_bits;
      logic                fits;
      assign top_bits = shifted[SH_W-1:OUT_W-1];
      assign fits     = (&top_bits) | ~(|top_bits);
      always_comb begin
         if (fits)
            res_o = shifted[OUT_W-1:0];
         else if (shifted[SH_W-1])
            res_o = MIN_V;
         else
            res_o = MAX_V;
      end
   end
endmodule

// File: rtl/sos_delay_line.sv
module sos_delay_line #(
   parameter int DATA_W = 18,
   parameter int DEPTH  = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     shift_en,
   input  logic signed [DATA_W-1:0] din,
   output logic signed [DATA_W-1:0] tap_o [DEPTH]
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("sos_delay_line: DEPTH must be at least 1");
   end

   logic signed [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (shift_en) begin
         mem[0] <= din;
         for (int i = 1; i < DEPTH; i++) mem[i] <= mem[i-1];
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_tap
      assign tap_o[i] = mem[i];
   end
endmodule

// File: rtl/iir_sos_df2.sv
module iir_sos_df2
   import sos_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int COEF_W = 18,
   parameter int FRAC_W = SOS_FRAC_W_DEF
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   input  logic signed [COEF_W-1:0] coef_gain,
   input  logic signed [COEF_W-1:0] coef_a1,
   input  logic signed [COEF_W-1:0] coef_a2,
   input  logic signed [COEF_W-1:0] coef_b0,
   input  logic signed [COEF_W-1:0] coef_b1,
   input  logic signed [COEF_W-1:0] coef_b2,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);
   localparam int PROD_W     = DATA_W + COEF_W;
   localparam int GAIN_ACC_W = acc_width(PROD_W, 1);
   localparam int FB_ACC_W   = acc_width(PROD_W, 2);
   localparam int REC_ACC_W  = FB_ACC_W + 1;
   localparam int FF_ACC_W   = acc_width(PROD_W, 3);
   localparam int N_STATE    = 2;

   if (DATA_W < 2) begin : g_bad_data
      $error("iir_sos_df2: DATA_W must be at least 2");
   end
   if (FRAC_W < 1 || FRAC_W >= COEF_W) begin : g_bad_frac
      $error("iir_sos_df2: FRAC_W must lie in 1..COEF_W-1");
   end

   // ---------------- recursive stage ----------------
   logic signed [DATA_W-1:0] st_tap [N_STATE];
   logic signed [DATA_W-1:0] st_d1, st_d2;
   assign st_d1 = st_tap[0];
   assign st_d2 = st_tap[1];

   logic signed [DATA_W-1:0] gain_samp [1];
   logic signed [COEF_W-1:0] gain_coef [1];
   logic signed [GAIN_ACC_W-1:0] gain_term;
   assign gain_samp[0] = in_data;
   assign gain_coef[0] = coef_gain;

   sos_prod_sum #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .N_TERMS(1), .ACC_W(GAIN_ACC_W)
   ) u_gain (
      .samp_i(gain_samp), .coef_i(gain_coef), .sum_o(gain_term)
   );

   logic signed [DATA_W-1:0] fb_samp [2];
   logic signed [COEF_W-1:0] fb_coef [2];
   logic signed [FB_ACC_W-1:0] fb_sum;
   assign fb_samp[0] = st_d1;
   assign fb_samp[1] = st_d2;
   assign fb_coef[0] = coef_a1;
   assign fb_coef[1] = coef_a2;

   sos_prod_sum #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .N_TERMS(2), .ACC_W(FB_ACC_W)
   ) u_feedback (
      .samp_i(fb_samp), .coef_i(fb_coef), .sum_o(fb_sum)
   );

   logic signed [REC_ACC_W-1:0] rec_acc;
   logic signed [DATA_W-1:0]    d_new;
   assign rec_acc = REC_ACC_W'(gain_term) - REC_ACC_W'(fb_sum);

   sos_round_sat #(
      .IN_W(REC_ACC_W), .FRAC_W(FRAC_W), .OUT_W(DATA_W)
   ) u_state_rnd (
      .acc_i(rec_acc), .res_o(d_new)
   );

   sos_delay_line #(
      .DATA_W(DATA_W), .DEPTH(N_STATE)
   ) u_state (
      .clk(clk), .rst(rst), .shift_en(in_valid), .din(d_new), .tap_o(st_tap)
   );

   // ---------------- intermediate register ----------------
   logic                     mid_valid;
   logic signed [DATA_W-1:0] mid_taps [3];

   always_ff @(posedge clk) begin
      if (rst) begin
         mid_valid <= 1'b0;
         for (int i = 0; i < 3; i++) mid_taps[i] <= '0;
      end else begin
         mid_valid <= in_valid;
         if (in_valid) begin
            mid_taps[0] <= d_new;
            mid_taps[1] <= st_d1;
            mid_taps[2] <= st_d2;
         end
      end
   end

   // ---------------- feedforward stage ----------------
   logic signed [COEF_W-1:0] ff_coef [3];
   logic signed [FF_ACC_W-1:0] ff_sum;
   logic signed [DATA_W-1:0]   y_new;
   assign ff_coef[0] = coef_b0;
   assign ff_coef[1] = coef_b1;
   assign ff_coef[2] = coef_b2;

   sos_prod_sum #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .N_TERMS(3), .ACC_W(FF_ACC_W)
   ) u_feedfwd (
      .samp_i(mid_taps), .coef_i(ff_coef), .sum_o(ff_sum)
   );

   sos_round_sat #(
      .IN_W(FF_ACC_W), .FRAC_W(FRAC_W), .OUT_W(DATA_W)
   ) u_out_rnd (
      .acc_i(ff_sum), .res_o(y_new)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= mid_valid;
         if (mid_valid) out_data <= y_new;
      end
   end
endmodule

// File: rtl/sos_df2_chk.sv
module sos_df2_chk #(
   parameter int DATA_W = 18
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic                     mid_valid,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_data,
   input logic signed [DATA_W-1:0] st_d1,
   input logic signed [DATA_W-1:0] st_d2
);
   logic [1:0] strobe_trail;
   always_ff @(posedge clk) begin
      if (rst) strobe_trail <= '0;
      else     strobe_trail <= {strobe_trail[0], in_valid};
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && !mid_valid && st_d1 == '0 && st_d2 == '0));

   // R2
   out_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid == strobe_trail[1]);

   // R3
   state_shift_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (st_d2 == $past(st_d1)));

   // R8
   idle_state_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(st_d1) && $stable(st_d2)));

   // R8
   idle_out_chk: assert property (@(posedge clk) disable iff (rst)
      !mid_valid |=> $stable(out_data));
endmodule

bind iir_sos_df2 sos_df2_chk #(.DATA_W(DATA_W)) u_df2_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .mid_valid(mid_valid),
   .out_valid(out_valid), .out_data(out_data), .st_d1(st_d1), .st_d2(st_d2)
);

// File: tb/test_iir_sos_df2.sv
module test_iir_sos_df2;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic signed [17:0] in_data = '0;
   logic signed [17:0] c_g = '0, c_a1 = '0, c_a2 = '0, c_b0 = '0, c_b1 = '0, c_b2 = '0;
   logic out_valid;
   logic signed [17:0] out_data;

   int checks = 0;
   int errors = 0;
   longint m_g, m_a1, m_a2, m_b0, m_b1, m_b2, m_d1, m_d2;

   always #5 clk = ~clk;

   iir_sos_df2 i_iir_sos_df2 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .coef_gain(c_g), .coef_a1(c_a1), .coef_a2(c_a2),
      .coef_b0(c_b0), .coef_b1(c_b1), .coef_b2(c_b2),
      .out_valid(out_valid), .out_data(out_data)
   );

   // Half-gain pole, unity gain and unity b0: impulse response walks exact halves.
   localparam int VEC_N = 10;
   localparam int STIM [VEC_N] = '{1000, 0, 0, 0, 0, -1000, 0, 0, 0, 0};
   localparam int EXPV [VEC_N] = '{1000, 500, 250, 125, 63, -968, -484, -242, -121, -60};

   function automatic longint rnd_sat(input longint acc);
      longint r;
      r = (acc + 64'sd32768) >>> 16;
      if (r > 131071) r = 131071;
      else if (r < -131072) r = -131072;
      return r;
   endfunction

   function automatic longint model_step(input longint x);
      longint dn, y;
      dn = rnd_sat(m_g * x - (m_a1 * m_d1 + m_a2 * m_d2));
      y  = rnd_sat(m_b0 * dn + m_b1 * m_d1 + m_b2 * m_d2);
      m_d2 = m_d1;
      m_d1 = dn;
      return y;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_coef(input int g, input int a1, input int a2,
                           input int b0, input int b1, input int b2);
      c_g = 18'(g); c_a1 = 18'(a1); c_a2 = 18'(a2);
      c_b0 = 18'(b0); c_b1 = 18'(b1); c_b2 = 18'(b2);
      m_g = g; m_a1 = a1; m_a2 = a2; m_b0 = b0; m_b1 = b1; m_b2 = b2;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      m_d1 = 0;
      m_d2 = 0;
   endtask

   // One sample, then wait for its result: valid must show after the second edge.
   task automatic send_chk(input int x, input longint exp, input string req);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 18'(x);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check({req, " valid"}, longint'(out_valid), 1);
      check(req, longint'(out_data), exp);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      m_d1 = 0; m_d2 = 0;
      set_coef(65536, -32768, 0, 65536, 0, 0);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: idle output after reset
      check("R1 out_valid", longint'(out_valid), 0);
      check("R1 out_data", longint'(out_data), 0);

      // R3 R4 R5: table walk, ties of both signs
      for (int i = 0; i < VEC_N; i++)
         send_chk(STIM[i], EXPV[i], "R5 table");

      // R1: reset mid-run clears history, impulse reproduces the first entry
      do_reset();
      send_chk(1000, 1000, "R1 history cleared");

      // R2: exact timing of a single sample
      do_reset();
      @(negedge clk);
      in_valid = 1'b1; in_data = 18'(1000);
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 not yet", longint'(out_valid), 0);
      @(negedge clk);
      check("R2 on time", longint'(out_valid), 1);
      check("R2 data", longint'(out_data), 1000);
      @(negedge clk);
      check("R2 one cycle", longint'(out_valid), 0);

      // R8: idle gap keeps state and output
      repeat (5) begin
         @(negedge clk);
         check("R8 idle valid", longint'(out_valid), 0);
         check("R8 idle data", longint'(out_data), 1000);
      end
      send_chk(0, 500, "R8 state held");

      // R3 R4: realistic section, step response against the model
      set_coef(25428, -100958, 44020, 65536, -37762, 65536);
      do_reset();
      for (int i = 0; i < 30; i++) begin
         longint e;
         e = model_step(10000);
         send_chk(10000, e, "R4 step");
      end

      // R2: back-to-back burst
      begin
         longint e [4];
         int xs [4] = '{-20000, 30000, 5, -7};
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k >= 2) begin
               check("R2 burst valid", longint'(out_valid), 1);
               check("R2 burst data", longint'(out_data), e[k-2]);
            end
            if (k < 4) begin
               e[k] = model_step(xs[k]);
               in_valid = 1'b1;
               in_data  = 18'(xs[k]);
            end else begin
               in_valid = 1'b0;
            end
         end
         @(negedge clk);
         check("R2 burst end", longint'(out_valid), 0);
      end

      // R6: state clamps, gain ~2 with full-scale input
      set_coef(131071, 0, 0, 65536, 0, 0);
      do_reset();
      send_chk(131071, 131071, "R6 state high");
      send_chk(-131072, -131072, "R6 state low");

      // R7: output clamps while state stays in range
      set_coef(65536, 0, 0, 98304, 0, 0);
      do_reset();
      send_chk(100000, 131071, "R7 out high");
      send_chk(-131072, -131072, "R7 out low");
      send_chk(1000, 1500, "R7 in range");

      // R6 R7: strong feedback, both clamp points in play
      set_coef(65536, -124518, 62259, 65536, 65536, 65536);
      do_reset();
      for (int i = 0; i < 20; i++) begin
         longint e;
         e = model_step(131071);
         send_chk(131071, e, "R7 heavy step");
      end
      for (int i = 0; i < 10; i++) begin
         longint e;
         e = model_step(-131072);
         send_chk(-131072, e, "R6 heavy step");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule